// File: doc/BRIEF.md
# Framebuffer Scan-Out Controller

This block turns a framebuffer in a shared, single-port video memory into a raster on a parallel RGB output. It generates the line and frame timing for a 320 by 240 visible area at about 60 frames per second. It fetches pixel words from memory itself. It also gives a host CPU access to the same memory while the display keeps refreshing.

The memory clock runs at twice the pixel rate. Every pixel therefore spans two clock cycles. The first cycle is a video slot, which the block uses for its own fetch. The second cycle is a CPU slot. A CPU request that arrives in a video slot is held off with `cpu_ready` low until the next CPU slot. A second access policy is available: it grants memory to the CPU only while the pixel being generated lies outside the visible area.

Two colour formats are supported. The direct format stores one 16-bit 5:6:5 word per pixel, so consecutive pixels alternate between the even and the odd memory bank. The indexed format packs four 4-bit colour indices per word, and each index selects one of sixteen 16-bit palette registers. The CPU reads and writes the palette registers through the same port, without waiting for a slot.

Top module: `fb_scanout`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SYNC+H_BP pixels and a frame lasts V_ACT+V_FP+V_SYNC+V_BP lines; each pixel takes two clock cycles, and `vid_de` is high exactly for pixels 0..H_ACT-1 of lines 0..V_ACT-1, counting from the first cycle after reset.
- R2: `vid_hsync` is high (active high) for pixels H_ACT+H_FP .. H_ACT+H_FP+H_SYNC-1 of every line; `vid_vsync` is high for all pixels of lines V_ACT+V_FP .. V_ACT+V_FP+V_SYNC-1; both stay aligned with `vid_de`.
- R3: The outputs for pixel k (whose two cycles are 2k and 2k+1 after reset) are presented during cycles 2k+2 and 2k+3, and the colour outputs are zero whenever `vid_de` is low.
- R4: With `pix_mode`=0 (direct), visible pixel (h,v) shows the word at address FB_BASE + v*H_ACT + h, with red in bits 15:11, green in bits 10:5 and blue in bits 4:0; consecutive pixels come from consecutive word addresses, so they alternate between banks by address bit 0.
- R5: With `pix_mode`=1 (indexed), visible pixel (h,v) uses the word at FB_BASE + (v*H_ACT+h)/4. Bits 4*(h%4)+3 .. 4*(h%4) of that word give the palette index, so the lowest nibble is the leftmost pixel, and the pixel shows the selected 5:6:5 palette entry. H_ACT must be a multiple of 4.
- R6: With `cpu_policy`=0, a memory request is accepted (`cpu_ready` high) only in the odd cycle of each pixel. A request raised in an odd cycle is accepted at once, and one raised in an even cycle is accepted exactly one cycle later.
- R7: With `cpu_policy`=1, a memory request is accepted only in the odd cycle of a pixel that lies outside the visible area.
- R8: An accepted memory write stores `cpu_wdata` at `cpu_addr`. An accepted read returns the stored word on `cpu_rdata` with `cpu_rvalid` high in the next cycle.
- R9: With `cpu_pal`=1, the request targets palette entry `cpu_addr[3:0]` and is accepted in the same cycle under either policy. A read returns the entry one cycle later. A write accepted in the even cycle of pixel k already affects pixel k, and a write accepted in the odd cycle affects it from pixel k+1.
- R10: During and directly after reset, `vid_de`, `vid_hsync`, `vid_vsync`, the colour outputs and `cpu_rvalid` are low, and all palette entries read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_mode | input | 1 | 0 = direct 5:6:5, 1 = 4-bit indexed |
| cpu_policy | input | 1 | 0 = interleaved slots, 1 = CPU memory access only outside the visible area |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_pal | input | 1 | 1 = palette register, 0 = video memory |
| cpu_addr | input | AW | Word address, or palette index in bits 3:0 |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Request accepted at this clock edge |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 16 | Read data |
| mem_addr | output | AW | Video memory word address |
| mem_we | output | 1 | Video memory write enable |
| mem_wdata | output | 16 | Video memory write data |
| mem_rdata | input | 16 | Video memory read data, one cycle after the address |
| vid_de | output | 1 | Visible-area enable |
| vid_hsync | output | 1 | Line sync, active high |
| vid_vsync | output | 1 | Frame sync, active high |
| vid_r | output | 5 | Red |
| vid_g | output | 6 | Green |
| vid_b | output | 5 | Blue |

## Verification
The raster is compared against an independent pixel-by-pixel model in three runs: direct colour with interleaved CPU access, indexed colour with interleaved access, and direct colour with blanking-only access. The direct run shows whether the fetch address walks the frame linearly. The indexed run separates the order of the nibbles within a word from the palette lookup. Random CPU reads and writes to memory outside the frame are issued on random cycles of both parities, so slot waits of zero and of one cycle are both exercised. Under the blanking-only policy the same traffic shows whether a grant ever falls inside the visible area. Palette writes issued while the visible area is being drawn check the pixel at which each write takes effect.

// File: rtl/fbs_pkg.sv
`timescale 1ns/1ps
package fbs_pkg;
    // Memory slot owner within one pixel period
    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    // Pixel word width and colour index width
    localparam int WORD_W = 16;
    localparam int NIB_W  = 4;
    localparam int PIX_PER_WORD = WORD_W / NIB_W;
    localparam int SUB_W  = $clog2(PIX_PER_WORD);
    localparam int PAL_N  = 1 << NIB_W;
endpackage

// File: rtl/fbs_timing.sv
`timescale 1ns/1ps
module fbs_timing #(
    parameter int H_ACT  = 320,
    parameter int H_FP   = 40,
    parameter int H_SYNC = 64,
    parameter int H_BP   = 84,
    parameter int V_ACT  = 240,
    parameter int V_FP   = 4,
    parameter int V_SYNC = 3,
    parameter int V_BP   = 15,
    parameter int SUB_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             slot_o,
    output logic [SUB_W-1:0] h_sub_o,
    output logic             act_o,
    output logic             v_act_o,
    output logic             hs_o,
    output logic             vs_o
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW = $clog2(H_TOT + 1);
    localparam int VW = $clog2(V_TOT + 1);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
    localparam logic [HW-1:0] H_A    = HW'(H_ACT);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_A    = VW'(V_ACT);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SYNC);

    typedef struct packed {
        logic          slot;
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d      = tim_q;
        tim_d.slot = ~tim_q.slot;
        if (tim_q.slot) begin
            if (tim_q.h == H_LAST) begin
                tim_d.h = '0;
                tim_d.v = (tim_q.v == V_LAST) ? '0 : tim_q.v + 1'b1;
            end else begin
                tim_d.h = tim_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign slot_o  = tim_q.slot;
    assign h_sub_o = tim_q.h[SUB_W-1:0];
    assign v_act_o = tim_q.v < V_A;
    assign act_o   = (tim_q.h < H_A) && v_act_o;
    assign hs_o    = (tim_q.h >= HS_BEG) && (tim_q.h < HS_END);
    assign vs_o    = (tim_q.v >= VS_BEG) && (tim_q.v < VS_END);

    // R1: the pixel position advances only at the end of a CPU slot
    a_r1_pixel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_q.slot |=> $stable(tim_q.h) && $stable(tim_q.v));
endmodule

// File: rtl/fbs_palette.sv
`timescale 1ns/1ps
module fbs_palette #(
    parameter int ENTRIES = 16,
    parameter int CW      = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [CW-1:0] wdata_i,
    input  logic [IW-1:0] vidx_i,
    output logic [CW-1:0] vcol_o,
    input  logic [IW-1:0] cidx_i,
    output logic [CW-1:0] ccol_o
);
    typedef struct packed {
        logic [ENTRIES-1:0][CW-1:0] ent;
    } pal_t;

    pal_t pal_d, pal_q;

    always_comb begin
        pal_d = pal_q;
        if (we_i) pal_d.ent[widx_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pal_q <= '0;
        else        pal_q <= pal_d;
    end

    assign vcol_o = pal_q.ent[vidx_i];
    assign ccol_o = pal_q.ent[cidx_i];
endmodule

// File: rtl/fbs_pixel.sv
`timescale 1ns/1ps
module fbs_pixel #(
    parameter int AW = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_i,
    input  logic                          act_i,
    input  logic                          v_act_i,
    input  logic                          hs_i,
    input  logic                          vs_i,
    input  logic [fbs_pkg::SUB_W-1:0]     h_sub_i,
    input  logic                          mode_i,
    input  logic [fbs_pkg::WORD_W-1:0]    mem_rdata_i,
    input  logic [fbs_pkg::WORD_W-1:0]    pal_col_i,
    output logic                          fetch_o,
    output logic [AW-1:0]                 vaddr_o,
    output logic [fbs_pkg::NIB_W-1:0]     pal_idx_o,
    output logic                          de_o,
    output logic                          hs_o,
    output logic                          vs_o,
    output logic [fbs_pkg::WORD_W-1:0]    rgb_o
);
    import fbs_pkg::*;

    typedef struct packed {
        logic [AW-1:0]     vaddr;
        logic [WORD_W-1:0] word;
        logic              de;
        logic              hs;
        logic              vs;
        logic [WORD_W-1:0] rgb;
    } pix_t;

    pix_t pix_d, pix_q;
    logic             grp_start;
    logic             new_word;
    logic [WORD_W-1:0] cur_word;

    always_comb begin
        grp_start = (h_sub_i == '0);
        new_word  = !mode_i || grp_start;
        fetch_o   = act_i && (slot_i == SLOT_VIDEO) && new_word;
        cur_word  = new_word ? mem_rdata_i : pix_q.word;
        pal_idx_o = cur_word[NIB_W*int'(h_sub_i) +: NIB_W];

        pix_d = pix_q;
        if (fetch_o)  pix_d.vaddr = pix_q.vaddr + 1'b1;
        if (!v_act_i) pix_d.vaddr = '0;
        if (slot_i == SLOT_CPU) begin
            pix_d.de  = act_i;
            pix_d.hs  = hs_i;
            pix_d.vs  = vs_i;
            pix_d.rgb = act_i ? (mode_i ? pal_col_i : cur_word) : '0;
            if (act_i && mode_i && grp_start) pix_d.word = mem_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign vaddr_o = pix_q.vaddr;
    assign de_o    = pix_q.de;
    assign hs_o    = pix_q.hs;
    assign vs_o    = pix_q.vs;
    assign rgb_o   = pix_q.rgb;

    // R3: outputs change only at the edge closing a pixel's CPU slot
    a_r3_hold_over_video_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i == SLOT_VIDEO) |=> $stable(pix_q.de) && $stable(pix_q.rgb));
    // R2: sync pulses never overlap the visible area
    a_r2_sync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_q.hs || pix_q.vs) |-> !pix_q.de);
    // R4: the fetch address restarts from zero outside the visible lines
    a_r4_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !v_act_i |=> pix_q.vaddr == '0);
endmodule

// File: rtl/fbs_arbiter.sv
`timescale 1ns/1ps
module fbs_arbiter #(
    parameter int AW      = 18,
    parameter int FB_BASE = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slot_i,
    input  logic                       act_i,
    input  logic                       policy_i,
    input  logic                       cpu_req_i,
    input  logic                       cpu_we_i,
    input  logic                       cpu_pal_i,
    input  logic [AW-1:0]              cpu_addr_i,
    input  logic [fbs_pkg::WORD_W-1:0] cpu_wdata_i,
    input  logic                       fetch_i,
    input  logic [AW-1:0]              vaddr_i,
    input  logic [fbs_pkg::WORD_W-1:0] pal_ccol_i,
    input  logic [fbs_pkg::WORD_W-1:0] mem_rdata_i,
    output logic [AW-1:0]              mem_addr_o,
    output logic                       mem_we_o,
    output logic [fbs_pkg::WORD_W-1:0] mem_wdata_o,
    output logic                       cpu_ready_o,
    output logic                       pal_we_o,
    output logic                       cpu_rvalid_o,
    output logic [fbs_pkg::WORD_W-1:0] cpu_rdata_o
);
    import fbs_pkg::*;

    localparam logic [AW-1:0] BASE = AW'(FB_BASE);

    typedef struct packed {
        logic              rvalid;
        logic              rpal;
        logic [WORD_W-1:0] pdata;
    } arb_t;

    arb_t arb_d, arb_q;
    logic slot_open;
    logic mem_grant;

    always_comb begin
        slot_open   = (slot_i == SLOT_CPU) && (!policy_i || !act_i);
        cpu_ready_o = cpu_req_i && (cpu_pal_i || slot_open);
        mem_grant   = cpu_req_i && !cpu_pal_i && slot_open;
        mem_addr_o  = fetch_i ? (BASE + vaddr_i) : cpu_addr_i;
        mem_we_o    = mem_grant && cpu_we_i;
        mem_wdata_o = cpu_wdata_i;
        pal_we_o    = cpu_req_i && cpu_pal_i && cpu_we_i;

        arb_d        = arb_q;
        arb_d.rvalid = cpu_ready_o && !cpu_we_i;
        arb_d.rpal   = cpu_pal_i;
        arb_d.pdata  = pal_ccol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign cpu_rvalid_o = arb_q.rvalid;
    assign cpu_rdata_o  = arb_q.rpal ? arb_q.pdata : mem_rdata_i;

    // R6: a CPU write never lands in the cycle of a video fetch
    a_r6_write_not_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !fetch_i);
    // R7: under the blanking policy no memory write occurs in the visible area
    a_r7_blank_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i && act_i) |-> !mem_we_o);
    // R8: read data is only flagged after a read request was present
    a_r8_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid_o |-> $past(cpu_req_i && !cpu_we_i));
endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout #(
    parameter int H_ACT   = 320,
    parameter int H_FP    = 40,
    parameter int H_SYNC  = 64,
    parameter int H_BP    = 84,
    parameter int V_ACT   = 240,
    parameter int V_FP    = 4,
    parameter int V_SYNC  = 3,
    parameter int V_BP    = 15,
    parameter int AW      = 18,
    parameter int FB_BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_mode,
    input  logic          cpu_policy,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_pal,
    input  logic [AW-1:0] cpu_addr,
    input  logic [15:0]   cpu_wdata,
    output logic          cpu_ready,
    output logic          cpu_rvalid,
    output logic [15:0]   cpu_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          vid_de,
    output logic          vid_hsync,
    output logic          vid_vsync,
    output logic [4:0]    vid_r,
    output logic [5:0]    vid_g,
    output logic [4:0]    vid_b
);
    import fbs_pkg::*;

    localparam int PAL_IW = $clog2(PAL_N);

    logic              slot;
    logic [SUB_W-1:0]  h_sub;
    logic              act, v_act, hs, vs;
    logic              fetch;
    logic [AW-1:0]     vaddr;
    logic [NIB_W-1:0]  pal_idx;
    logic [WORD_W-1:0] pal_vcol, pal_ccol;
    logic              pal_we;
    logic [WORD_W-1:0] rgb;

    fbs_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .SUB_W(SUB_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .h_sub_o(h_sub),
        .act_o(act), .v_act_o(v_act), .hs_o(hs), .vs_o(vs)
    );

    fbs_palette #(.ENTRIES(PAL_N), .CW(WORD_W)) u_palette (
        .clk(clk), .rst_n(rst_n), .we_i(pal_we),
        .widx_i(cpu_addr[PAL_IW-1:0]), .wdata_i(cpu_wdata),
        .vidx_i(pal_idx), .vcol_o(pal_vcol),
        .cidx_i(cpu_addr[PAL_IW-1:0]), .ccol_o(pal_ccol)
    );

    fbs_pixel #(.AW(AW)) u_pixel (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .act_i(act), .v_act_i(v_act),
        .hs_i(hs), .vs_i(vs), .h_sub_i(h_sub), .mode_i(pix_mode),
        .mem_rdata_i(mem_rdata), .pal_col_i(pal_vcol), .fetch_o(fetch),
        .vaddr_o(vaddr), .pal_idx_o(pal_idx), .de_o(vid_de), .hs_o(vid_hsync),
        .vs_o(vid_vsync), .rgb_o(rgb)
    );

    fbs_arbiter #(.AW(AW), .FB_BASE(FB_BASE)) u_arbiter (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .act_i(act), .policy_i(cpu_policy),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_pal_i(cpu_pal),
        .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .fetch_i(fetch),
        .vaddr_i(vaddr), .pal_ccol_i(pal_ccol), .mem_rdata_i(mem_rdata),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .cpu_ready_o(cpu_ready), .pal_we_o(pal_we), .cpu_rvalid_o(cpu_rvalid),
        .cpu_rdata_o(cpu_rdata)
    );

    assign vid_r = rgb[15:11];
    assign vid_g = rgb[10:5];
    assign vid_b = rgb[4:0];
endmodule

// File: tb/tb_fb_scanout.sv
`timescale 1ns/1ps
module tb_fb_scanout;
    localparam int HA = 16, HFP = 2, HSY = 3, HBP = 3;
    localparam int VA = 6,  VFP = 1, VSY = 2, VBP = 1;
    localparam int HT = HA + HFP + HSY + HBP;
    localparam int VT = VA + VFP + VSY + VBP;
    localparam int AW = 8;
    localparam int RAMN = 256;
    localparam int CPU_LO = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_mode = 1'b0, cpu_policy = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_pal = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic cpu_ready, cpu_rvalid;
    logic [15:0] cpu_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic vid_de, vid_hsync, vid_vsync;
    logic [4:0] vid_r, vid_b;
    logic [5:0] vid_g;

    fb_scanout #(
        .H_ACT(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
        .V_ACT(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .AW(AW), .FB_BASE(0)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_mode(pix_mode), .cpu_policy(cpu_policy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_pal(cpu_pal), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .vid_de(vid_de),
        .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_r(vid_r), .vid_g(vid_g),
        .vid_b(vid_b)
    );

    always #2.5 clk = ~clk;

    // Synchronous memory model with a load port used during reset
    logic [15:0] ram [RAMN];
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    always @(posedge clk) begin
        if (ld_en) ram[ld_addr] <= ld_data;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] sh [RAMN];
    logic [15:0] pal_sh [16];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, expv);
        end
    endtask

    function automatic bit pix_act(input int p);
        int h = p % HT;
        int v = (p / HT) % VT;
        return (h < HA) && (v < VA);
    endfunction

    // Video monitor: compare, then compute the pixel whose output loads at this cycle's end
    bit mon_on = 1'b0;
    bit e_de, e_hs, e_vs;
    logic [15:0] e_rgb;
    always @(negedge clk) begin
        if (!mon_on) begin
            e_de = 0; e_hs = 0; e_vs = 0; e_rgb = '0;
        end else begin
            if (cyc < 2) begin
                chk({vid_de, vid_hsync, vid_vsync} == 3'b000 && {vid_r, vid_g, vid_b} == 16'h0 && !cpu_rvalid,
                    "R10 reset outputs", {vid_de, vid_hsync, vid_vsync, cpu_rvalid, vid_r, vid_g, vid_b}, 0);
            end else begin
                chk(vid_de == e_de, "R1 de", vid_de, e_de);
                chk(vid_hsync == e_hs && vid_vsync == e_vs, "R2 sync", {vid_hsync, vid_vsync}, {e_hs, e_vs});
                chk({vid_r, vid_g, vid_b} == e_rgb, pix_mode ? "R5 indexed colour (R3)" : "R4 direct colour (R3)",
                    {vid_r, vid_g, vid_b}, e_rgb);
            end
            if (cyc % 2 == 1) begin
                int p, h, v;
                logic [15:0] w;
                p = cyc / 2;
                h = p % HT;
                v = (p / HT) % VT;
                e_de = (h < HA) && (v < VA);
                e_hs = (h >= HA + HFP) && (h < HA + HFP + HSY);
                e_vs = (v >= VA + VFP) && (v < VA + VFP + VSY);
                if (!e_de) e_rgb = '0;
                else if (!pix_mode) e_rgb = ram[v * HA + h];
                else begin
                    w = ram[(v * HA + h) / 4];
                    e_rgb = pal_sh[(w >> (4 * (h % 4))) & 16'hF];
                end
            end
        end
    end

    task automatic do_reset(input bit md, input bit pol);
        mon_on = 0;
        @(negedge clk);
        rst_n = 0; pix_mode = md; cpu_policy = pol; cpu_req = 0;
        for (int i = 0; i < RAMN; i++) begin
            ld_en = 1; ld_addr = AW'(i); ld_data = 16'($urandom); sh[i] = ld_data;
            @(negedge clk);
        end
        ld_en = 0;
        for (int i = 0; i < 16; i++) pal_sh[i] = '0;
        @(negedge clk);
        rst_n = 1;
        #1 mon_on = 1;
    endtask

    task automatic cpu_op(input bit pal, input bit we, input logic [AW-1:0] addr, input logic [15:0] data);
        int start, acc;
        logic [15:0] expd;
        @(negedge clk);
        cpu_req = 1; cpu_pal = pal; cpu_we = we; cpu_addr = addr; cpu_wdata = data;
        start = cyc;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
        end
        acc = cyc;
        if (pal) begin
            chk(acc == start, "R9 palette accepted at once", acc, start);
            expd = pal_sh[addr[3:0]];
        end else begin
            expd = sh[addr];
            chk(acc % 2 == 1, "R6 CPU slot parity", acc % 2, 1);
            if (!cpu_policy)
                chk(acc - start == ((start % 2 == 0) ? 1 : 0), "R6 slot wait", acc - start, (start % 2 == 0) ? 1 : 0);
            else
                chk(!pix_act(acc / 2), "R7 grant outside visible area", acc, 0);
        end
        @(posedge clk);
        if (we) begin
            if (pal) pal_sh[addr[3:0]] = data;
            else     sh[addr] = data;
        end
        @(negedge clk);
        cpu_req = 0;
        if (!we) begin
            chk(cpu_rvalid == 1'b1, pal ? "R9 read valid" : "R8 read valid", cpu_rvalid, 1);
            chk(cpu_rdata == expd, pal ? "R9 palette readback" : "R8 memory readback", cpu_rdata, expd);
        end
    endtask

    task automatic traffic(input int nops, input bit allow_pal);
        for (int i = 0; i < nops; i++) begin
            int kind, gap;
            kind = $urandom % 4;
            gap = $urandom % 4;
            for (int g = 0; g < gap; g++) @(negedge clk);
            if (kind >= 2 && !allow_pal) kind = kind - 2;
            case (kind)
                0: cpu_op(0, 1, AW'(CPU_LO + $urandom % (RAMN - CPU_LO)), 16'($urandom));
                1: cpu_op(0, 0, AW'(CPU_LO + $urandom % (RAMN - CPU_LO)), 16'h0);
                2: cpu_op(1, 1, AW'($urandom % 16), 16'($urandom));
                default: cpu_op(1, 0, AW'($urandom % 16), 16'h0);
            endcase
        end
    endtask

    task automatic run_until(input int ncyc);
        while (cyc < ncyc) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Direct colour, interleaved slots (R1-related timing, R4, R6, R8, R10)
        do_reset(1'b0, 1'b0);
        traffic(60, 1'b0);
        run_until(2 * HT * VT * 2 + 8);
        // Palette reset value (R10) and indexed colour with palette traffic (R5, R9)
        do_reset(1'b1, 1'b0);
        cpu_op(1, 0, AW'(5), 16'h0);
        for (int i = 0; i < 16; i++) cpu_op(1, 1, AW'(i), 16'($urandom));
        traffic(120, 1'b1);
        run_until(2 * HT * VT * 3 + 8);
        // Blanking-only policy (R7) with direct colour
        do_reset(1'b0, 1'b1);
        traffic(60, 1'b1);
        run_until(2 * HT * VT * 2 + 8);
        mon_on = 0;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule